// File: doc/BRIEF.md
# Parity-Preserving 2x2 Unsigned Multiplier Cell

This block multiplies two 2-bit unsigned operands. It builds the product entirely from three kinds of reversible gate models, all of which preserve parity. Fan-out copy gates (3-in/3-out) duplicate each operand bit. Mux-style gates (3-in/3-out) form the four bit products. Two 4-in/4-out gates, used as half adders, sum the cross terms. Every ancilla input is tied to zero. Each gate output that no later gate consumes leaves the cell, either as a product bit or as a garbage bit.

Every gate keeps the XOR of its inputs equal to the XOR of its outputs. A single comparison at the cell boundary is therefore enough to detect an upset on any one internal wire: the XOR of the operand bits is compared with the XOR of the product and garbage bits. No signal inside the cell is checked. A test input can invert any single gate output to exercise this detection. The product, garbage and error flag are registered, with a synchronous active-high reset.

Top module: `pp_mul2x2`

## Requirements
- R1: With `fault_en_i` low, `prod_o` equals the unsigned product `a_i*b_i` (4 bits) at the clock edge that follows the one where the operands were captured, i.e. one cycle of latency.
- R2: Every gate preserves parity. At the cell level, with no fault injected, the XOR of all bits of `prod_o` and `garbage_o` equals the XOR of all bits of `a_i` and `b_i`.
- R3: With `fault_en_i` low, `err_o` is 0 one cycle later, for all 16 operand pairs, including the cycle right after a fault is withdrawn.
- R4: With `fault_en_i` high, `err_o` is 1 one cycle later, for every value of `fault_sel_i` (0..31) and every operand pair.
- R5: With no fault, `garbage_o` holds these bits:
  - bits 0..3: copies of a0, a1, b0, b1.
  - bits 4+2n and 5+2n (product gate n, where n = 0..3 forms a0·b0, a1·b0, a0·b1, a1·b1 from x·y): x, then ~x·y.
  - bit 12: a1·b0. Bit 13: a1·b0·~(a0·b1).
  - bit 14: a1·b1. Bit 15: a1·b1·~c, where c = a1·b0·a0·b1.
- R6: `fault_sel_i` indexes gate outputs as follows:
  - copy gate g (g = 0..3 for a0, a1, b0, b1): outputs 3g..3g+2 in the order pass-through, copy 1, copy 2.
  - product gate n: outputs 12+3n..14+3n.
  - half adder k: outputs 24+4k..27+4k in the order pass, sum, carry, spare.

  Inverting an unconsumed output (index 0) inverts only garbage bit 0 and leaves the product unchanged. Inverting the first carry (index 26) propagates into the product: 0×0 gives 4.
- R7: A synchronous active-high `rst` clears `prod_o`, `garbage_o` and `err_o` to 0 at the next clock edge, regardless of the operands and of the fault inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 2 | Operand A, unsigned |
| b_i | input | 2 | Operand B, unsigned |
| fault_en_i | input | 1 | Invert the gate output selected by `fault_sel_i` |
| fault_sel_i | input | 5 | Index of the gate output to invert (R6) |
| prod_o | output | 4 | Registered product |
| garbage_o | output | 16 | Registered unconsumed gate outputs (R5) |
| err_o | output | 1 | Registered parity-mismatch flag |

## Verification
The hardest situation to reach is an upset on a wire buried between gates, such as a carry or an operand copy that feeds a product gate. From the ports alone, no operand value can ever disturb such a wire. The stimulus reaches it through the fault index: it sweeps all 32 gate outputs under all 16 operand pairs. It then aims at specific internal wires and checks both that the flag rises and that the product moves exactly as the upset would make it move.

// File: rtl/pp_mul_pkg.sv
package pp_mul_pkg;
  // operand width of the cell (structure below is built for 2)
  localparam int OPW       = 2;
  localparam int PROD_W    = 2 * OPW;
  // gate population
  localparam int N_CPY     = 2 * OPW;        // one copy gate per operand bit
  localparam int N_AND     = OPW * OPW;      // one product gate per bit pair
  localparam int N_HA      = 2;              // half adders
  localparam int CPY_OUTS  = 3;
  localparam int AND_OUTS  = 3;
  localparam int HA_OUTS   = 4;
  // flat gate-output index space used by fault injection
  localparam int OFS_CPY   = 0;
  localparam int OFS_AND   = OFS_CPY + N_CPY * CPY_OUTS;
  localparam int OFS_HA    = OFS_AND + N_AND * AND_OUTS;
  localparam int GATE_OUTS = OFS_HA + N_HA * HA_OUTS;
  localparam int FSEL_W    = $clog2(GATE_OUTS);
  // garbage: copy pass-through, two per product gate, two per half adder
  localparam int GOFS_AND  = N_CPY;
  localparam int GOFS_HA   = GOFS_AND + 2 * N_AND;
  localparam int GARB_W    = GOFS_HA + 2 * N_HA;

  typedef struct packed {
    logic [PROD_W-1:0] prod;
    logic [GARB_W-1:0] garb;
  } cell_out_t;
endpackage

// File: rtl/pp_gate_copy.sv
// 3-in/3-out fan-out gate: p = a, q = a ^ b, r = a ^ c
module pp_gate_copy (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = a_i ^ c_i;

  always_comb begin
    a_r2_copy_parity: assert (^{p_o, q_o, r_o} == ^{a_i, b_i, c_i});
  end
endmodule

// File: rtl/pp_gate_mux.sv
// 3-in/3-out parity-preserving mux gate:
// p = a ^ b, q = (~b & c) ^ (a & ~c), r = (b & c) ^ (a & ~c)
module pp_gate_mux (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = a_i ^ b_i;
  assign q_o = (~b_i & c_i) ^ (a_i & ~c_i);
  assign r_o = (b_i & c_i) ^ (a_i & ~c_i);

  always_comb begin
    a_r2_mux_parity: assert (^{p_o, q_o, r_o} == ^{a_i, b_i, c_i});
  end
endmodule

// File: rtl/pp_gate_ha.sv
// 4-in/4-out parity-preserving gate, half adder when c = d = 0:
// p = a, q = a ^ b, r = (a & b) ^ c, s = (b & d) ^ (~b & (a ^ d))
module pp_gate_ha (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic p_o,
  output logic q_o,
  output logic r_o,
  output logic s_o
);
  assign p_o = a_i;
  assign q_o = a_i ^ b_i;
  assign r_o = (a_i & b_i) ^ c_i;
  assign s_o = (b_i & d_i) ^ (~b_i & (a_i ^ d_i));

  always_comb begin
    a_r2_ha_parity: assert (^{p_o, q_o, r_o, s_o} == ^{a_i, b_i, c_i, d_i});
  end
endmodule

// File: rtl/pp_parity_chk.sv
// Boundary parity comparison: inputs and zero ancillas vs cell outputs
module pp_parity_chk
  import pp_mul_pkg::*;
(
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  cell_out_t      cell_i,
  output logic           mismatch_o
);
  logic in_par;
  logic out_par;

  // ancillas are all zero and contribute nothing to the input parity
  assign in_par     = ^{a_i, b_i};
  assign out_par    = ^{cell_i.prod, cell_i.garb};
  assign mismatch_o = in_par ^ out_par;
endmodule

// File: rtl/pp_mul2x2.sv
module pp_mul2x2
  import pp_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    a_i,
  input  logic [OPW-1:0]    b_i,
  input  logic              fault_en_i,
  input  logic [FSEL_W-1:0] fault_sel_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [GARB_W-1:0] garbage_o,
  output logic              err_o
);
  localparam logic ANC = 1'b0;

  logic [GATE_OUTS-1:0] fmask;
  logic [N_CPY-1:0]     src;
  logic [2:0]           cpy_o [N_CPY];
  logic [2:0]           and_o [N_AND];
  logic [3:0]           ha0_raw, ha1_raw, ha0_o, ha1_o;
  cell_out_t            cell_c;
  logic                 err_c;

  // one-hot inversion mask over the flat gate-output index space
  always_comb begin
    fmask = '0;
    if (fault_en_i) fmask[fault_sel_i] = 1'b1;
  end

  assign src = {b_i, a_i};   // copy gate order: a0, a1, b0, b1

  // fan-out stage
  for (genvar g = 0; g < N_CPY; g++) begin : g_cpy
    logic [2:0] raw;
    pp_gate_copy u_cpy (
      .a_i(src[g]), .b_i(ANC), .c_i(ANC),
      .p_o(raw[0]), .q_o(raw[1]), .r_o(raw[2])
    );
    assign cpy_o[g] = raw ^ fmask[OFS_CPY + CPY_OUTS*g +: CPY_OUTS];
  end

  // bit-product stage: gate n forms a[n%2] & b[n/2]
  for (genvar n = 0; n < N_AND; n++) begin : g_and
    localparam int AI = n % OPW;
    localparam int BI = OPW + n / OPW;
    localparam int AK = (n / OPW == 0) ? 1 : 2;
    localparam int BK = (n % OPW == 0) ? 1 : 2;
    logic [2:0] raw;
    pp_gate_mux u_and (
      .a_i(ANC), .b_i(cpy_o[AI][AK]), .c_i(cpy_o[BI][BK]),
      .p_o(raw[0]), .q_o(raw[1]), .r_o(raw[2])
    );
    assign and_o[n] = raw ^ fmask[OFS_AND + AND_OUTS*n +: AND_OUTS];
  end

  // first half adder: a1b0 + a0b1 -> sum is product bit 1, carry onward
  pp_gate_ha u_ha0 (
    .a_i(and_o[1][2]), .b_i(and_o[2][2]), .c_i(ANC), .d_i(ANC),
    .p_o(ha0_raw[0]), .q_o(ha0_raw[1]), .r_o(ha0_raw[2]), .s_o(ha0_raw[3])
  );
  assign ha0_o = ha0_raw ^ fmask[OFS_HA +: HA_OUTS];

  // second half adder: a1b1 + carry -> product bits 2 and 3
  pp_gate_ha u_ha1 (
    .a_i(and_o[3][2]), .b_i(ha0_o[2]), .c_i(ANC), .d_i(ANC),
    .p_o(ha1_raw[0]), .q_o(ha1_raw[1]), .r_o(ha1_raw[2]), .s_o(ha1_raw[3])
  );
  assign ha1_o = ha1_raw ^ fmask[OFS_HA + HA_OUTS +: HA_OUTS];

  // collect every unconsumed gate output
  always_comb begin
    cell_c.prod = {ha1_o[2], ha1_o[1], ha0_o[1], and_o[0][2]};
    for (int g = 0; g < N_CPY; g++) cell_c.garb[g] = cpy_o[g][0];
    for (int n = 0; n < N_AND; n++) begin
      cell_c.garb[GOFS_AND + 2*n]     = and_o[n][0];
      cell_c.garb[GOFS_AND + 2*n + 1] = and_o[n][1];
    end
    cell_c.garb[GOFS_HA]     = ha0_o[0];
    cell_c.garb[GOFS_HA + 1] = ha0_o[3];
    cell_c.garb[GOFS_HA + 2] = ha1_o[0];
    cell_c.garb[GOFS_HA + 3] = ha1_o[3];
  end

  pp_parity_chk u_chk (
    .a_i(a_i), .b_i(b_i), .cell_i(cell_c), .mismatch_o(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o    <= '0;
      garbage_o <= '0;
      err_o     <= 1'b0;
    end else begin
      prod_o    <= cell_c.prod;
      garbage_o <= cell_c.garb;
      err_o     <= err_c;
    end
  end

  // R2: fault-free cell keeps boundary parity
  always_comb begin
    if (!fault_en_i) a_r2_cell_parity: assert (err_c == 1'b0);
  end

  // R1: registered product equals the captured operands multiplied
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    !fault_en_i |=> prod_o == ({2'b00, $past(a_i)} * {2'b00, $past(b_i)}));

  // R3: no flag without an injected fault
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    !fault_en_i |=> !err_o);

  // R4: any single inverted gate output is flagged
  a_r4_detect: assert property (@(posedge clk) disable iff (rst)
    fault_en_i |=> err_o);
endmodule

// File: tb/sim_pp_mul2x2.sv
module sim_pp_mul2x2;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  a, b;
  logic        fen;
  logic [4:0]  fsel;
  logic [3:0]  prod;
  logic [15:0] garb;
  logic        err;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  pp_mul2x2 u0 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b),
    .fault_en_i(fen), .fault_sel_i(fsel),
    .prod_o(prod), .garbage_o(garb), .err_o(err)
  );

  // {a[1:0], b[1:0], a*b[3:0]}
  localparam logic [7:0] VEC [16] = '{
    8'h00, 8'h10, 8'h20, 8'h30,
    8'h40, 8'h51, 8'h62, 8'h73,
    8'h80, 8'h92, 8'hA4, 8'hB6,
    8'hC0, 8'hD3, 8'hE6, 8'hF9
  };

  function automatic logic [15:0] exp_garb(input logic [1:0] x, input logic [1:0] y);
    logic [15:0] g;
    logic [3:0]  xs, ys;
    logic        c1;
    xs = {x[1], x[0], x[1], x[0]};
    ys = {y[1], y[1], y[0], y[0]};
    g[0] = x[0]; g[1] = x[1]; g[2] = y[0]; g[3] = y[1];
    for (int n = 0; n < 4; n++) begin
      g[4 + 2*n] = xs[n];
      g[5 + 2*n] = ~xs[n] & ys[n];
    end
    c1 = x[1] & y[0] & x[0] & y[1];
    g[12] = x[1] & y[0];
    g[13] = (x[1] & y[0]) & ~(x[0] & y[1]);
    g[14] = x[1] & y[1];
    g[15] = (x[1] & y[1]) & ~c1;
    return g;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic apply(input logic [1:0] x, input logic [1:0] y,
                       input logic fe, input logic [4:0] fs);
    @(negedge clk);
    a = x; b = y; fen = fe; fsel = fs;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; a = 2'd3; b = 2'd3; fen = 1'b1; fsel = 5'd7;
    @(negedge clk); @(negedge clk);
    check("R7 reset prod", {28'd0, prod}, 32'd0);
    check("R7 reset garbage", {16'd0, garb}, 32'd0);
    check("R7 reset err", {31'd0, err}, 32'd0);
    rst = 1'b0;

    // table walk, fault-free
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][7:6], VEC[i][5:4], 1'b0, 5'd0);
      check("R1 product", {28'd0, prod}, {28'd0, VEC[i][3:0]});
      check("R3 err quiet", {31'd0, err}, 32'd0);
      check("R5 garbage", {16'd0, garb}, {16'd0, exp_garb(VEC[i][7:6], VEC[i][5:4])});
      check("R2 cell parity", {31'd0, ^{prod, garb}}, {31'd0, ^VEC[i][7:4]});
    end

    // every single gate output under every operand pair
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 32; s++) begin
        apply(VEC[i][7:6], VEC[i][5:4], 1'b1, 5'(s));
        check("R4 fault flagged", {31'd0, err}, 32'd1);
      end
    end

    // R6: unconsumed output inverted -> only garbage bit 0 moves
    apply(2'd2, 2'd3, 1'b1, 5'd0);
    check("R6 spare fault product", {28'd0, prod}, 32'd6);
    check("R6 spare fault garbage", {16'd0, garb}, {16'd0, exp_garb(2'd2, 2'd3) ^ 16'h0001});
    // R6: first carry inverted -> propagates to product bit 2
    apply(2'd0, 2'd0, 1'b1, 5'd26);
    check("R6 carry fault product", {28'd0, prod}, 32'd4);
    check("R4 carry fault err", {31'd0, err}, 32'd1);
    // R3: flag drops once the fault is withdrawn
    apply(2'd3, 2'd3, 1'b0, 5'd26);
    check("R3 fault withdrawn", {31'd0, err}, 32'd0);
    check("R1 after fault", {28'd0, prod}, 32'd9);

    // R7: mid-run reset with fault active
    @(negedge clk);
    rst = 1'b1; fen = 1'b1; fsel = 5'd30;
    @(negedge clk);
    check("R7 midrun prod", {28'd0, prod}, 32'd0);
    check("R7 midrun err", {31'd0, err}, 32'd0);
    check("R7 midrun garbage", {16'd0, garb}, 32'd0);
    rst = 1'b0; fen = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule